// File: doc/BRIEF.md
# AUX Transaction Retry Sequencer

This block turns a single read or write request on an AUX side channel into a finished transaction. A request names the direction, whether it targets the native register space or a tunnelled I2C device, a start address, a byte count and whether more I2C segments will follow. The block hands a channel engine one attempt at a time. It reads the engine's verdict on each attempt and decides among four outcomes: issue the attempt again, wait and then issue it, change it into a status poll, or stop with a final status.

Each kind of failure has its own counter and limit. These are native defers, I2C defers, timeouts, malformed replies, partial read acknowledgements and write-status polls. A transaction fails when any one counter goes past its limit. When an I2C transaction ends, the block sends one zero-length closing command to the same device with the continuation flag cleared. It does this when the caller said no segment follows, and also after any failure. The waits before retries are timed by a microsecond prescaler whose tick count is a parameter.

Top module: `aux_retry_seq`

## Requirements
- R1: On every main attempt of an I2C request, `attAddr` is `reqAddr` shifted right by one and `attMot` is 1. On a native request, `attAddr` equals `reqAddr` and `attMot` is 0.
- R2: Native defers (`resKind`=0, `resReply`=2) are retried. A read fails with status 2 on the 7th defer. A write fails with status 2 when the count of defers exceeds the larger of 6 and `cfgMaxDefer`.
- R3: Timeouts (`resKind`=1) are retried without a wait. The 3rd timeout ends the transaction with status 2 (timeout).
- R4: After the first malformed reply (`resKind`=2), the next attempt comes at least 400 microseconds later. The 2nd malformed reply ends with status 3 (protocol).
- R5: A read ACK (`resReply`=0) that returns fewer bytes than remain causes a retry of the remainder. `attLen` drops by the returned count and `attOffset` rises by it. A second such partial ACK ends with status 3.
- R6: A read ACK whose returned count exceeds the remaining length ends with status 3.
- R7: A write ACK with a nonzero returned count causes the next attempt to be a status request (`attStatusReq`=1, `attLen`=0, MOT kept). That attempt follows a wait of at least 300 microseconds. The 7th such ACK ends with status 2.
- R8: On a write, an I2C defer (`resReply`=8) causes an immediate zero-length status request. It clears the native-defer count and counts toward the same write defer limit as R2.
- R9: A native NACK (`resReply`=1) ends the transaction at once with status 1. A disconnect (`resKind`=3) ends it at once with status 4. Any other reply code ends it with status 5. A full ACK gives status 0.
- R10: When an I2C transaction finishes and either `reqMot` was 0 or the transaction failed, exactly one closing attempt follows, with `attLen`=0 and `attMot`=0. Its result is not examined. Native transactions never send this attempt.
- R11: After reset, and during reset, `busy`, `attValid` and `doneValid` are 0.
- R12: `attValid` and `doneValid` are single-cycle pulses. `doneStatus` is valid in the cycle `doneValid` is high, and no attempt is issued in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Starts a transaction when idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqI2c | input | 1 | 1 = tunnelled I2C, 0 = native space |
| reqMot | input | 1 | Further I2C segments follow |
| reqAddr | input | ADDR_W | Start address (I2C: 8-bit device address) |
| reqLen | input | LEN_W | Byte count |
| cfgMaxDefer | input | CNT_W | Extra write defer allowance |
| attValid | output | 1 | Attempt issue pulse |
| attWrite | output | 1 | Attempt is a write |
| attI2c | output | 1 | Attempt is I2C |
| attMot | output | 1 | Attempt carries the continuation flag |
| attStatusReq | output | 1 | Attempt is a write status poll |
| attAddr | output | ADDR_W | Attempt address |
| attLen | output | LEN_W | Attempt byte count |
| attOffset | output | LEN_W | Buffer offset of this attempt |
| resValid | input | 1 | Engine result pulse |
| resKind | input | 2 | 0 done, 1 timeout, 2 malformed, 3 disconnect |
| resReply | input | 4 | Reply code when resKind is 0 |
| resCount | input | LEN_W | Data bytes returned |
| busy | output | 1 | A transaction is in progress |
| doneValid | output | 1 | Final status pulse |
| doneStatus | output | 3 | 0 ok, 1 nack, 2 timeout, 3 protocol, 4 disconnect, 5 unknown |

## Verification
The checker takes for granted that the engine returns exactly one result for each attempt. It also assumes that result arrives at least one cycle after `attValid`, and that `startReq` is raised only while `busy` is low. The bench engine model follows these rules. It waits for the issue pulse, responds one cycle later with a one-cycle `resValid`, and starts the next transaction only after the `doneValid` pulse. Every result sequence comes from a two-entry script: a repeated result followed by a final one. This is enough to push each counter to its limit and one step past it.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

  typedef enum logic [1:0] {
    KIND_DONE    = 2'd0,
    KIND_TIMEOUT = 2'd1,
    KIND_INVALID = 2'd2,
    KIND_UNPLUG  = 2'd3
  } res_kind_e;

  localparam logic [3:0] RPL_ACK       = 4'd0;
  localparam logic [3:0] RPL_NACK      = 4'd1;
  localparam logic [3:0] RPL_DEFER     = 4'd2;
  localparam logic [3:0] RPL_I2C_DEFER = 4'd8;

  typedef enum logic [2:0] {
    TS_OK       = 3'd0,
    TS_NACK     = 3'd1,
    TS_TIMEOUT  = 3'd2,
    TS_PROTOCOL = 3'd3,
    TS_UNPLUG   = 3'd4,
    TS_UNKNOWN  = 3'd5
  } txn_status_e;

  typedef enum logic [2:0] {
    VD_RETRY,
    VD_WAIT_INV,
    VD_WAIT_ACK,
    VD_PASS,
    VD_FAIL
  } verdict_e;

  typedef struct packed {
    logic load;
    logic apply;
    logic endSel;
    logic dlyRun;
  } seq_strobe_t;

endpackage

// File: rtl/aux_retry_dp.sv
module aux_retry_dp
  import aux_retry_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int LEN_W        = 8,
  parameter int CNT_W        = 4,
  parameter int TICKS_PER_US = 100,
  parameter int INV_WAIT_US  = 400,
  parameter int ACK_WAIT_US  = 300,
  parameter int LIM_DEFER    = 6,
  parameter int LIM_TIMEOUT  = 2,
  parameter int LIM_INVALID  = 1,
  parameter int LIM_PARTIAL  = 1,
  parameter int LIM_ACKPOLL  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_strobe_t       strb,
  input  logic              reqWrite,
  input  logic              reqI2c,
  input  logic              reqMot,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [CNT_W-1:0]  cfgMaxDefer,
  input  res_kind_e         resKind,
  input  logic [3:0]        resReply,
  input  logic [LEN_W-1:0]  resCount,
  output verdict_e          verdict,
  output logic              endNeeded,
  output logic              dlyZero,
  output logic              attWrite,
  output logic              attI2c,
  output logic              attMot,
  output logic              attStatusReq,
  output logic [ADDR_W-1:0] attAddr,
  output logic [LEN_W-1:0]  attLen,
  output logic [LEN_W-1:0]  attOffset,
  output logic [2:0]        doneStatus
);

  localparam int INV_TICKS = TICKS_PER_US * INV_WAIT_US;
  localparam int ACK_TICKS = TICKS_PER_US * ACK_WAIT_US;
  localparam int DLY_MAX   = (INV_TICKS > ACK_TICKS) ? INV_TICKS : ACK_TICKS;
  localparam int DLY_W     = $clog2(DLY_MAX + 1);
  localparam logic [CNT_W:0] LIM_DEF_W = (CNT_W+1)'(LIM_DEFER);

  logic              latWr, latI2c, latMot, statusReq, endMode;
  logic [ADDR_W-1:0] latAddr;
  logic [LEN_W-1:0]  remLen, offset;
  logic [CNT_W-1:0]  toCnt, invCnt, ndCnt, i2dCnt, partCnt, ackCnt;
  logic [DLY_W-1:0]  dlyCnt;
  txn_status_e       statusReg, failCode;
  logic [CNT_W:0]    cfgWide, deferLim;

  function automatic logic overLimit(input logic [CNT_W-1:0] c, input logic [CNT_W:0] lim);
    return ({1'b0, c} + (CNT_W+1)'(1)) > lim;
  endfunction

  assign cfgWide  = {1'b0, cfgMaxDefer};
  assign deferLim = latWr ? ((cfgWide > LIM_DEF_W) ? cfgWide : LIM_DEF_W) : LIM_DEF_W;

  // Judge the current engine result against the running counters.
  always_comb begin
    verdict  = VD_RETRY;
    failCode = TS_UNKNOWN;
    unique case (resKind)
      KIND_TIMEOUT: if (overLimit(toCnt, (CNT_W+1)'(LIM_TIMEOUT))) begin
        verdict = VD_FAIL; failCode = TS_TIMEOUT;
      end
      KIND_INVALID: if (overLimit(invCnt, (CNT_W+1)'(LIM_INVALID))) begin
        verdict = VD_FAIL; failCode = TS_PROTOCOL;
      end else verdict = VD_WAIT_INV;
      KIND_UNPLUG: begin verdict = VD_FAIL; failCode = TS_UNPLUG; end
      default: begin
        if (!latWr && (resCount > remLen)) begin
          verdict = VD_FAIL; failCode = TS_PROTOCOL;
        end else begin
          case (resReply)
            RPL_ACK: begin
              if (latWr) begin
                if (resCount != '0) begin
                  if (overLimit(ackCnt, (CNT_W+1)'(LIM_ACKPOLL))) begin
                    verdict = VD_FAIL; failCode = TS_TIMEOUT;
                  end else verdict = VD_WAIT_ACK;
                end else begin
                  verdict = VD_PASS; failCode = TS_OK;
                end
              end else if (resCount < remLen) begin
                if (overLimit(partCnt, (CNT_W+1)'(LIM_PARTIAL))) begin
                  verdict = VD_FAIL; failCode = TS_PROTOCOL;
                end
              end else begin
                verdict = VD_PASS; failCode = TS_OK;
              end
            end
            RPL_NACK: begin verdict = VD_FAIL; failCode = TS_NACK; end
            RPL_DEFER: if (overLimit(ndCnt, deferLim)) begin
              verdict = VD_FAIL; failCode = TS_TIMEOUT;
            end
            RPL_I2C_DEFER: if (overLimit(i2dCnt, deferLim)) begin
              verdict = VD_FAIL; failCode = TS_TIMEOUT;
            end
            default: begin verdict = VD_FAIL; failCode = TS_UNKNOWN; end
          endcase
        end
      end
    endcase
  end

  assign endNeeded = latI2c && (!latMot || (verdict == VD_FAIL));
  assign dlyZero   = (dlyCnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latWr <= 1'b0; latI2c <= 1'b0; latMot <= 1'b0; latAddr <= '0;
      remLen <= '0; offset <= '0; statusReq <= 1'b0; endMode <= 1'b0;
      toCnt <= '0; invCnt <= '0; ndCnt <= '0; i2dCnt <= '0; partCnt <= '0; ackCnt <= '0;
      dlyCnt <= '0; statusReg <= TS_OK;
    end else begin
      if (strb.load) begin
        latWr <= reqWrite; latI2c <= reqI2c; latMot <= reqMot; latAddr <= reqAddr;
        remLen <= reqLen; offset <= '0; statusReq <= 1'b0; endMode <= 1'b0;
        toCnt <= '0; invCnt <= '0; ndCnt <= '0; i2dCnt <= '0; partCnt <= '0; ackCnt <= '0;
        statusReg <= TS_OK;
      end
      if (strb.endSel) endMode <= 1'b1;
      if (strb.dlyRun) dlyCnt <= dlyCnt - DLY_W'(1);
      if (strb.apply) begin
        if (verdict == VD_PASS || verdict == VD_FAIL) statusReg <= failCode;
        if (verdict == VD_WAIT_INV) dlyCnt <= DLY_W'(INV_TICKS - 1);
        if (verdict == VD_WAIT_ACK) dlyCnt <= DLY_W'(ACK_TICKS - 1);
        unique case (resKind)
          KIND_TIMEOUT: toCnt  <= toCnt + CNT_W'(1);
          KIND_INVALID: invCnt <= invCnt + CNT_W'(1);
          KIND_UNPLUG:  ;
          default: begin
            toCnt  <= '0;
            invCnt <= '0;
            case (resReply)
              RPL_ACK: begin
                ndCnt <= '0;
                if (latWr && resCount != '0) begin
                  statusReq <= 1'b1;
                  remLen    <= '0;
                  ackCnt    <= ackCnt + CNT_W'(1);
                end else if (!latWr && resCount < remLen) begin
                  remLen  <= remLen - resCount;
                  offset  <= offset + resCount;
                  partCnt <= partCnt + CNT_W'(1);
                end
              end
              RPL_DEFER: ndCnt <= ndCnt + CNT_W'(1);
              RPL_I2C_DEFER: begin
                ndCnt  <= '0;
                i2dCnt <= i2dCnt + CNT_W'(1);
                if (latWr) begin
                  statusReq <= 1'b1;
                  remLen    <= '0;
                end
              end
              default: ;
            endcase
          end
        endcase
      end
    end
  end

  assign attWrite     = latWr;
  assign attI2c       = latI2c;
  assign attMot       = latI2c && !endMode;
  assign attStatusReq = statusReq && !endMode;
  assign attAddr      = latI2c ? (latAddr >> 1) : latAddr;
  assign attLen       = endMode ? '0 : remLen;
  assign attOffset    = endMode ? '0 : offset;
  assign doneStatus   = statusReg;

endmodule

// File: rtl/aux_retry_ctl.sv
module aux_retry_ctl
  import aux_retry_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        startReq,
  input  logic        resValid,
  input  verdict_e    verdict,
  input  logic        endNeeded,
  input  logic        dlyZero,
  output seq_strobe_t strb,
  output logic        attValid,
  output logic        doneValid,
  output logic        busy
);

  typedef enum logic [2:0] {
    S_IDLE, S_ISSUE, S_WAIT, S_DELAY, S_END_ISSUE, S_END_WAIT, S_DONE
  } state_e;

  state_e state, nxt;

  always_comb begin
    nxt  = state;
    strb = '0;
    unique case (state)
      S_IDLE: if (startReq) begin strb.load = 1'b1; nxt = S_ISSUE; end
      S_ISSUE: nxt = S_WAIT;
      S_WAIT: if (resValid) begin
        strb.apply = 1'b1;
        case (verdict)
          VD_RETRY: nxt = S_ISSUE;
          VD_WAIT_INV, VD_WAIT_ACK: nxt = S_DELAY;
          default: if (endNeeded) begin
            strb.endSel = 1'b1;
            nxt = S_END_ISSUE;
          end else nxt = S_DONE;
        endcase
      end
      S_DELAY: if (dlyZero) nxt = S_ISSUE; else strb.dlyRun = 1'b1;
      S_END_ISSUE: nxt = S_END_WAIT;
      S_END_WAIT: if (resValid) nxt = S_DONE;
      S_DONE: nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  assign attValid  = (state == S_ISSUE) || (state == S_END_ISSUE);
  assign doneValid = (state == S_DONE);
  assign busy      = (state != S_IDLE);

endmodule

// File: rtl/aux_retry_seq.sv
module aux_retry_seq
  import aux_retry_pkg::*;
#(
  parameter int ADDR_W       = 20,
  parameter int LEN_W        = 8,
  parameter int CNT_W        = 4,
  parameter int TICKS_PER_US = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic              reqWrite,
  input  logic              reqI2c,
  input  logic              reqMot,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LEN_W-1:0]  reqLen,
  input  logic [CNT_W-1:0]  cfgMaxDefer,
  output logic              attValid,
  output logic              attWrite,
  output logic              attI2c,
  output logic              attMot,
  output logic              attStatusReq,
  output logic [ADDR_W-1:0] attAddr,
  output logic [LEN_W-1:0]  attLen,
  output logic [LEN_W-1:0]  attOffset,
  input  logic              resValid,
  input  logic [1:0]        resKind,
  input  logic [3:0]        resReply,
  input  logic [LEN_W-1:0]  resCount,
  output logic              busy,
  output logic              doneValid,
  output logic [2:0]        doneStatus
);

  seq_strobe_t strb;
  verdict_e    verdict;
  logic        endNeeded, dlyZero;

  aux_retry_ctl u_ctl (
    .clk, .rst_n, .startReq, .resValid, .verdict, .endNeeded, .dlyZero,
    .strb, .attValid, .doneValid, .busy
  );

  aux_retry_dp #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .TICKS_PER_US(TICKS_PER_US)
  ) u_dp (
    .clk, .rst_n, .strb, .reqWrite, .reqI2c, .reqMot, .reqAddr, .reqLen, .cfgMaxDefer,
    .resKind(res_kind_e'(resKind)), .resReply, .resCount,
    .verdict, .endNeeded, .dlyZero,
    .attWrite, .attI2c, .attMot, .attStatusReq, .attAddr, .attLen, .attOffset, .doneStatus
  );

endmodule

// File: rtl/aux_retry_chk.sv
module aux_retry_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             attValid,
  input logic             attWrite,
  input logic             attI2c,
  input logic             attMot,
  input logic             attStatusReq,
  input logic [LEN_W-1:0] attLen,
  input logic             busy,
  input logic             doneValid
);

  AST_ATT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    attValid |=> !attValid);                                            // R12
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);                                          // R12
  AST_NO_ATT_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |-> !attValid);                                           // R12
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!attValid && !doneValid));                               // R11
  AST_CLOSE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (attValid && attI2c && !attMot) |-> (attLen == '0));                // R10
  AST_POLL_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (attValid && attStatusReq) |-> (attWrite && attLen == '0));         // R7

endmodule

bind aux_retry_seq aux_retry_chk #(.LEN_W(LEN_W)) u_chk (.*);

// File: tb/aux_retry_seq_bench.sv
`timescale 1ns/1ps
module aux_retry_seq_bench;

  localparam int ADDR_W = 20, LEN_W = 8, CNT_W = 4, TPU = 2;
  localparam int INV_T = TPU * 400, ACK_T = TPU * 300;
  localparam logic [ADDR_W-1:0] ADDR = 20'h050A3;

  logic clk = 0, rst_n = 0;
  logic startReq = 0, reqWrite = 0, reqI2c = 0, reqMot = 0;
  logic [ADDR_W-1:0] reqAddr = ADDR;
  logic [LEN_W-1:0]  reqLen = '0;
  logic [CNT_W-1:0]  cfgMaxDefer = 4'd8;
  logic attValid, attWrite, attI2c, attMot, attStatusReq, busy, doneValid;
  logic [ADDR_W-1:0] attAddr;
  logic [LEN_W-1:0]  attLen, attOffset;
  logic resValid = 0;
  logic [1:0] resKind = '0;
  logic [3:0] resReply = '0;
  logic [LEN_W-1:0] resCount = '0;
  logic [2:0] doneStatus;

  int total = 0, bad = 0, cycles = 0;

  always #4 clk = ~clk;

  aux_retry_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .TICKS_PER_US(TPU))
  u_aux_retry_seq (.*);

  function automatic logic [13:0] rr(input int k, input int rp, input int c);
    return {2'(k), 4'(rp), 8'(c)};
  endfunction

  typedef struct packed {
    logic [3:0]  rq;
    logic        wr, i2c, mot;
    logic [7:0]  len;
    logic [3:0]  n;
    logic [13:0] a, b;
    logic [2:0]  st;
    logic        endc, sr;
    logic [7:0]  lastLen;
  } vec_t;

  localparam int NV = 22;
  // rq, wr, i2c, mot, len, n, repeated result, final result, status, close, poll, last length
  localparam vec_t VECS [NV] = '{
    '{1, 0,0,0, 4, 1, rr(0,0,4), rr(0,0,4), 0, 0,0, 4},  // R1 plain native read
    '{2, 0,0,0, 4, 7, rr(0,2,0), rr(0,0,4), 0, 0,0, 4},  // R2 six defers tolerated
    '{2, 0,0,0, 4, 7, rr(0,2,0), rr(0,2,0), 2, 0,0, 4},  // R2 seventh defer fails
    '{2, 1,0,0, 2, 9, rr(0,2,0), rr(0,0,0), 0, 0,0, 2},  // R2 write limit raised to 8
    '{2, 1,0,0, 2, 9, rr(0,2,0), rr(0,2,0), 2, 0,0, 2},  // R2 ninth write defer fails
    '{3, 0,0,0, 4, 3, rr(1,0,0), rr(0,0,4), 0, 0,0, 4},  // R3 two timeouts tolerated
    '{3, 0,0,0, 4, 3, rr(1,0,0), rr(1,0,0), 2, 0,0, 4},  // R3 third timeout fails
    '{4, 0,0,0, 4, 2, rr(2,0,0), rr(0,0,4), 0, 0,0, 4},  // R4 one malformed reply, wait
    '{4, 0,0,0, 4, 2, rr(2,0,0), rr(2,0,0), 3, 0,0, 4},  // R4 second malformed fails
    '{5, 0,0,0, 4, 2, rr(0,0,2), rr(0,0,2), 0, 0,0, 2},  // R5 partial then rest
    '{5, 0,0,0, 6, 2, rr(0,0,2), rr(0,0,2), 3, 0,0, 4},  // R5 second partial fails
    '{6, 0,0,0, 4, 1, rr(0,0,4), rr(0,0,5), 3, 0,0, 4},  // R6 overrun
    '{7, 1,1,1, 3, 2, rr(0,0,1), rr(0,0,0), 0, 0,1, 0},  // R7 one status poll
    '{7, 1,1,1, 3, 7, rr(0,0,1), rr(0,0,1), 2, 1,1, 0},  // R7 poll limit exceeded
    '{8, 1,1,1, 2, 2, rr(0,8,0), rr(0,0,0), 0, 0,1, 0},  // R8 I2C defer then ack
    '{8, 1,1,0, 2, 9, rr(0,8,0), rr(0,8,0), 2, 1,1, 0},  // R8 I2C defer limit on write
    '{9, 0,0,0, 4, 1, rr(0,0,4), rr(0,1,0), 1, 0,0, 4},  // R9 native nack
    '{9, 0,0,0, 4, 1, rr(0,0,4), rr(3,0,0), 4, 0,0, 4},  // R9 disconnect
    '{9, 0,1,1, 2, 1, rr(0,0,2), rr(0,4,0), 5, 1,0, 2},  // R9 unknown code, R10 close
    '{10,0,1,1, 2, 1, rr(0,0,2), rr(0,0,2), 0, 0,0, 2},  // R10 no close while continuing
    '{10,0,1,0, 2, 1, rr(0,0,2), rr(0,0,2), 0, 1,0, 2},  // R10 close on last segment
    '{10,1,0,0, 2, 1, rr(0,0,0), rr(0,1,0), 1, 0,0, 2}   // R10 native never closes
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitEvent(output int gap, output bit gotAtt, output bit gotDone);
    gap = 0; gotAtt = 0; gotDone = 0;
    while (!attValid && !doneValid && gap < 5000) begin
      @(negedge clk);
      gap++;
    end
    gotAtt = attValid;
    gotDone = doneValid;
  endtask

  task automatic respond(input logic [13:0] r);
    @(negedge clk);
    resValid = 1; resKind = r[13:12]; resReply = r[11:8]; resCount = r[7:0];
    @(negedge clk);
    resValid = 0;
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int gap, expGap;
    bit gA, gD;
    logic [ADDR_W-1:0] expAddr;
    string t;
    expAddr = v.i2c ? (ADDR >> 1) : ADDR;
    expGap = (v.a[13:12] == 2) ? INV_T :
             (v.wr && v.a[13:8] == 6'd0 && v.a[7:0] != 0) ? ACK_T : 0;
    @(negedge clk);
    startReq = 1; reqWrite = v.wr; reqI2c = v.i2c; reqMot = v.mot; reqLen = v.len;
    @(negedge clk);
    startReq = 0;
    for (int i = 0; i < int'(v.n); i++) begin
      t = $sformatf("R%0d vec%0d att%0d", v.rq, idx, i);
      waitEvent(gap, gA, gD);
      check(gA, {t, " attempt issued"}, gA, 1);
      if (!gA) return;
      check(attAddr == expAddr, {t, " R1 address"}, attAddr, expAddr);
      check(attMot == v.i2c, {t, " R1 continuation flag"}, attMot, v.i2c);
      if (i >= 1) begin
        check(attStatusReq == v.sr, {t, " R7 R8 status poll"}, attStatusReq, v.sr);
        if (expGap > 0) check(gap >= expGap, {t, " R4 R7 wait"}, gap, expGap);
      end
      if (i == int'(v.n) - 1) begin
        check(attLen == v.lastLen, {t, " R5 length"}, attLen, v.lastLen);
        if (!v.wr) check(attOffset == v.len - v.lastLen, {t, " R5 offset"},
                         attOffset, v.len - v.lastLen);
      end
      respond((i == int'(v.n) - 1) ? v.b : v.a);
    end
    t = $sformatf("R%0d vec%0d", v.rq, idx);
    if (v.endc) begin
      waitEvent(gap, gA, gD);
      check(gA && !attMot && attLen == 0, {t, " R10 closing attempt"}, {attMot, attLen}, 0);
      check(attAddr == expAddr, {t, " R10 closing address"}, attAddr, expAddr);
      if (gA) respond(rr(1, 0, 0));
    end
    waitEvent(gap, gA, gD);
    check(gD && !gA, {t, " R10 done without extra attempt"}, {gA, gD}, 1);
    check(doneStatus == v.st, {t, " R9 final status"}, doneStatus, v.st);
    @(negedge clk);
    check(!doneValid && !busy, {t, " R12 done pulse"}, {doneValid, busy}, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog R12 actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int gap;
    bit gA, gD;
    repeat (3) @(negedge clk);
    check(!busy && !attValid && !doneValid, "R11 during reset", {busy, attValid, doneValid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check(!busy && !attValid && !doneValid, "R11 after reset", {busy, attValid, doneValid}, 0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R11: reset in the middle of a transaction
    @(negedge clk);
    startReq = 1; reqWrite = 0; reqI2c = 1; reqMot = 1; reqLen = 8'd3;
    @(negedge clk);
    startReq = 0;
    waitEvent(gap, gA, gD);
    check(gA, "R11 attempt before reset", gA, 1);
    rst_n = 0;
    @(negedge clk);
    check(!busy && !attValid && !doneValid, "R11 mid-transaction reset", {busy, attValid, doneValid}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(!busy && !attValid && !doneValid, "R11 stays idle", {busy, attValid, doneValid}, 0);

    // R12: attempt pulse lasts one cycle
    startReq = 1; reqWrite = 0; reqI2c = 0; reqMot = 0; reqLen = 8'd1;
    @(negedge clk);
    startReq = 0;
    waitEvent(gap, gA, gD);
    @(negedge clk);
    check(gA && !attValid, "R12 attempt pulse width", attValid, 0);
    respond(rr(0, 0, 1));
    waitEvent(gap, gA, gD);
    check(gD && doneStatus == 3'd0, "R12 single-byte read done", doneStatus, 0);
    @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule